// File: doc/BRIEF.md
# Data Acquisition Converter Register Controller

This block sits between a byte-wide host bus and a 12-bit successive-approximation converter core. Through two shared configuration ports the host sets the local channel, the input mode, the local and global gains, the filter corner, the source slot, the range and the read selection. The block drives each of these as a control output. A third location starts a recalibration. A fourth starts a conversion, and reading it returns conversion-complete status.

Conversions run in one of two ways. In the regular mode, one conversion runs per start command. In the auto-acquire mode, conversions repeat on a fixed pacing period, and an optional active-low external gate can suspend them. Each finished result is latched and stays readable while the next conversion runs. The result is returned left-justified in 16 bits: the high byte carries result bits 11:4, and the low byte carries bits 3:0 in its upper nibble.

The sequencer has four states:
- SQ_IDLE waits for work.
- SQ_CONV waits for the core's done pulse.
- SQ_PACE waits out the auto-acquire period.
- SQ_CAL holds off all activity after a recalibration.

Its transitions are:
- SQ_IDLE to SQ_CONV on a regular start, or on an enabled auto run.
- SQ_CONV to SQ_PACE (auto-acquire) or to SQ_IDLE (regular) when the core reports done.
- SQ_PACE to SQ_CONV when the period has elapsed and the gate allows it.
- SQ_PACE to SQ_IDLE when auto-acquire is switched off.
- Any state to SQ_CAL on a recalibrate write.
- SQ_CAL to SQ_IDLE when the hold count has run out.

Top module: `daq_adc_ctrl`

## Requirements
- R1: A write to address 0x80 sets the following fields, all visible on the outputs in the cycle after the write edge:
  - channel = bits 3:0
  - single-ended = bit 4
  - local gain x10 = bit 5
  - auto-acquire = bit 6
  - narrow filter = bit 7
- R2: A write to address 0x81 sets the following fields, all visible in the cycle after the write edge:
  - slot = bits 3:0
  - read-low select = bit 4
  - bipolar range = bit 5
  - global gain code = bits 7:6 (0=x1, 1=x2, 2=x5, 3=x10)
- R3: Reads return data in the same cycle, as follows. Any other address reads as zero.

  | Address | Condition | Returns |
  |---|---|---|
  | 0x81 | — | result bits 11:4 |
  | 0x80 | read-low select = 1 | {result bits 3:0, 4'b0000} |
  | 0x80 | read-low select = 0 | status byte: bit 0 = end of conversion, bit 1 = converting, bit 2 = calibrating, upper bits zero |
  | 0x9B | — | {7'b0, end of conversion} |
- R4: In the regular mode, a write to 0x9B while the block is idle raises adc_start for exactly one cycle, the cycle after the write edge. A start written while a conversion or a calibration is in progress produces no adc_start.
- R5: The result latch changes only when adc_done arrives during a conversion. Between such events it holds, including while a new conversion is running.
- R6: The end-of-conversion flag is set by a latched result. It is cleared by a read of 0x81 or by the start of a new conversion.
- R7: In auto-acquire mode, with the gate not selected, conversions repeat without host action. Successive adc_start pulses are exactly PACE_CYC cycles apart, and the repetition stops when auto-acquire is cleared.
- R8: With gate_sel=1 in auto-acquire mode, a high gate_n (seen through a SYNC_STAGES-flop synchronizer) suspends new conversions and a low gate_n resumes them. A conversion already running when the suspend takes effect still completes and is latched.
- R9: A write to 0x9A does the following:
  - clears every configuration field to zero in the next cycle;
  - discards a conversion in progress, so its done is not latched;
  - reports calibrating and blocks all starts for CAL_CYC cycles;
  - after that, starts are accepted again.
- R10: After reset the following hold:
  - all configuration outputs are zero;
  - the end-of-conversion flag, the result and adc_start are zero;
  - the status byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Host location offset |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid while bus_rd is high |
| gate_sel | input | 1 | 1 selects the external gate for auto-acquire |
| gate_n | input | 1 | Asynchronous gate, low enables and high suspends |
| adc_start | output | 1 | One-cycle start pulse to the converter core |
| adc_done | input | 1 | One-cycle completion pulse from the core |
| adc_result | input | 12 | Core result, valid with adc_done |
| chan_sel | output | 4 | Local channel number |
| single_ended | output | 1 | 1 = single-ended, 0 = differential |
| local_gain_x10 | output | 1 | 1 = local gain x10 |
| auto_acq | output | 1 | 1 = auto-acquire mode |
| filter_narrow | output | 1 | 1 = narrow filter corner |
| slot_sel | output | 4 | Source slot number |
| read_low_sel | output | 1 | 1 = port 0x80 reads the low data byte |
| range_bipolar | output | 1 | 1 = bipolar range |
| global_gain | output | 2 | Global gain code |

## Verification
Each result has a fixed due time:
- Configuration outputs and the adc_start pulse are due in the cycle after the capturing write edge.
- Read data is combinational during the read cycle.
- An end-of-conversion clear from a high-byte read or a start shows on the next access.

The bench drives inputs on falling edges and samples either one falling edge after the write or 1 ns into a read cycle, so every check lands in the cycle in which the value is due. Start pulses are timestamped by a cycle counter, so pacing is checked as an exact gap of PACE_CYC. Gate and recalibration effects are checked after the synchronizer delay and the CAL_CYC window, with margin, and the lack of starts is checked by counting adc_start pulses over whole windows.

// File: rtl/daq_pkg.sv
`timescale 1ns/1ps
package daq_pkg;
    localparam int RES_W = 12;

    localparam logic [7:0] LOC_CFG_A = 8'h80;
    localparam logic [7:0] LOC_CFG_B = 8'h81;
    localparam logic [7:0] LOC_RECAL = 8'h9A;
    localparam logic [7:0] LOC_SOC   = 8'h9B;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_PACE,
        SQ_CAL
    } seq_state_t;

    // bit layout is decoded by the host, so packing order matters
    typedef struct packed {
        logic       narrow;
        logic       auto_acq;
        logic       lgain10;
        logic       single;
        logic [3:0] chan;
    } cfg_a_t;

    typedef struct packed {
        logic [1:0] ggain;
        logic       bipolar;
        logic       rd_low;
        logic [3:0] slot;
    } cfg_b_t;
endpackage

// File: rtl/daq_cfg_regs.sv
`timescale 1ns/1ps
module daq_cfg_regs
    import daq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic         cal_req,
    input  logic [7:0]   wdata,
    output cfg_a_t       cfg_a,
    output cfg_b_t       cfg_b
);
    always_ff @(posedge clk) begin
        if (!rst_n || cal_req) begin
            cfg_a <= '0;
            cfg_b <= '0;
        end else begin
            if (wr_a) cfg_a <= cfg_a_t'(wdata);
            if (wr_b) cfg_b <= cfg_b_t'(wdata);
        end
    end

    AST_RECAL_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> (cfg_a == '0 && cfg_b == '0)); // R9
    AST_CFG_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_a && !cal_req) |=> $stable(cfg_a)); // R1
    AST_CFG_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_b && !cal_req) |=> $stable(cfg_b)); // R2
endmodule

// File: rtl/daq_gate_sync.sv
`timescale 1ns/1ps
module daq_gate_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [SYNC_STAGES-1:0] chain;

    // reset to the suspending level so nothing launches before the gate is seen
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], async_in};
    end

    assign sync_out = chain[SYNC_STAGES-1];
endmodule

// File: rtl/daq_seq.sv
`timescale 1ns/1ps
module daq_seq
    import daq_pkg::*;
#(
    parameter int PACE_CYC = 2000,
    parameter int CAL_CYC  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic cal_req,
    input  logic auto_mode,
    input  logic run_ok,
    input  logic adc_done,
    output logic adc_start,
    output logic launch,
    output logic done_acc,
    output logic conv_busy,
    output logic cal_busy
);
    localparam int PW = $clog2(PACE_CYC + 1);
    localparam int CW = $clog2(CAL_CYC + 1);

    seq_state_t st, nxt;
    logic [PW-1:0] pace_cnt;
    logic [CW-1:0] cal_cnt;
    logic          pace_done, cal_done;

    assign pace_done = (pace_cnt == PW'(PACE_CYC - 1));
    assign cal_done  = (cal_cnt  == CW'(CAL_CYC - 1));

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            adc_start <= 1'b0;
            pace_cnt  <= '0;
            cal_cnt   <= '0;
        end else begin
            st        <= nxt;
            adc_start <= launch;
            if (launch)          pace_cnt <= '0;
            else if (!pace_done) pace_cnt <= pace_cnt + 1'b1;
            if (cal_req)                          cal_cnt <= '0;
            else if (st == SQ_CAL && !cal_done)   cal_cnt <= cal_cnt + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        nxt      = st;
        launch   = 1'b0;
        done_acc = 1'b0;
        unique case (st)
            SQ_IDLE: begin
                if ((start_req && !auto_mode) || (auto_mode && run_ok)) begin
                    launch = 1'b1;
                    nxt    = SQ_CONV;
                end
            end
            SQ_CONV: begin
                if (adc_done) begin
                    done_acc = 1'b1;
                    nxt      = auto_mode ? SQ_PACE : SQ_IDLE;
                end
            end
            SQ_PACE: begin
                if (!auto_mode) begin
                    nxt = SQ_IDLE;
                end else if (pace_done && run_ok) begin
                    launch = 1'b1;
                    nxt    = SQ_CONV;
                end
            end
            SQ_CAL: begin
                if (cal_done) nxt = SQ_IDLE;
            end
        endcase
        if (cal_req) begin
            nxt      = SQ_CAL;
            launch   = 1'b0;
            done_acc = 1'b0;
        end
    end

    assign conv_busy = (st == SQ_CONV);
    assign cal_busy  = (st == SQ_CAL);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R4
    AST_NO_START_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |=> !adc_start); // R9
    AST_GATE_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !run_ok && !conv_busy) |=> !adc_start); // R8
    AST_REGULAR_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && start_req) |=> !adc_start); // R4
endmodule

// File: rtl/daq_data_latch.sv
`timescale 1ns/1ps
module daq_data_latch
    import daq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_acc,
    input  logic [RES_W-1:0] adc_result,
    input  logic             launch,
    input  logic             cal_req,
    input  logic             rd_en,
    input  logic [7:0]       rd_addr,
    input  logic             rd_low_sel,
    input  logic             conv_busy,
    input  logic             cal_busy,
    output logic [7:0]       rdata
);
    logic [RES_W-1:0] res_q;
    logic             eoc_q;
    logic             hi_read;

    assign hi_read = rd_en && (rd_addr == LOC_CFG_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            eoc_q <= 1'b0;
        end else begin
            if (done_acc) res_q <= adc_result;
            if (cal_req)                eoc_q <= 1'b0;
            else if (done_acc)          eoc_q <= 1'b1;
            else if (launch || hi_read) eoc_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            case (rd_addr)
                LOC_CFG_A: rdata = rd_low_sel ? {res_q[3:0], 4'b0000}
                                              : {5'b0, cal_busy, conv_busy, eoc_q};
                LOC_CFG_B: rdata = res_q[11:4];
                LOC_SOC:   rdata = {7'b0, eoc_q};
                default:   rdata = 8'h00;
            endcase
        end
    end

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_acc |=> $stable(res_q)); // R5
    AST_EOC_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && !cal_req) |=> eoc_q); // R6
    AST_EOC_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_read && !done_acc) |=> !eoc_q); // R6
endmodule

// File: rtl/daq_adc_ctrl.sv
`timescale 1ns/1ps
module daq_adc_ctrl
    import daq_pkg::*;
#(
    parameter int PACE_CYC    = 2000,
    parameter int CAL_CYC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             gate_sel,
    input  logic             gate_n,
    output logic             adc_start,
    input  logic             adc_done,
    input  logic [RES_W-1:0] adc_result,
    output logic [3:0]       chan_sel,
    output logic             single_ended,
    output logic             local_gain_x10,
    output logic             auto_acq,
    output logic             filter_narrow,
    output logic [3:0]       slot_sel,
    output logic             read_low_sel,
    output logic             range_bipolar,
    output logic [1:0]       global_gain
);
    cfg_a_t cfg_a;
    cfg_b_t cfg_b;
    logic   wr_a, wr_b, cal_req, start_req;
    logic   gate_hi, run_ok;
    logic   launch, done_acc, conv_busy, cal_busy;

    assign wr_a      = bus_wr && (bus_addr == LOC_CFG_A);
    assign wr_b      = bus_wr && (bus_addr == LOC_CFG_B);
    assign cal_req   = bus_wr && (bus_addr == LOC_RECAL);
    assign start_req = bus_wr && (bus_addr == LOC_SOC);
    assign run_ok    = !gate_sel || !gate_hi;

    daq_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b),
        .cal_req(cal_req), .wdata(bus_wdata), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    daq_gate_sync #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst_n(rst_n), .async_in(gate_n), .sync_out(gate_hi)
    );

    daq_seq #(.PACE_CYC(PACE_CYC), .CAL_CYC(CAL_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cal_req(cal_req),
        .auto_mode(cfg_a.auto_acq), .run_ok(run_ok), .adc_done(adc_done),
        .adc_start(adc_start), .launch(launch), .done_acc(done_acc),
        .conv_busy(conv_busy), .cal_busy(cal_busy)
    );

    daq_data_latch u_data (
        .clk(clk), .rst_n(rst_n), .done_acc(done_acc), .adc_result(adc_result),
        .launch(launch), .cal_req(cal_req), .rd_en(bus_rd), .rd_addr(bus_addr),
        .rd_low_sel(cfg_b.rd_low), .conv_busy(conv_busy), .cal_busy(cal_busy),
        .rdata(bus_rdata)
    );

    assign chan_sel       = cfg_a.chan;
    assign single_ended   = cfg_a.single;
    assign local_gain_x10 = cfg_a.lgain10;
    assign auto_acq       = cfg_a.auto_acq;
    assign filter_narrow  = cfg_a.narrow;
    assign slot_sel       = cfg_b.slot;
    assign read_low_sel   = cfg_b.rd_low;
    assign range_bipolar  = cfg_b.bipolar;
    assign global_gain    = cfg_b.ggain;
endmodule

// File: tb/daq_adc_ctrl_bench.sv
`timescale 1ns/1ps
module daq_adc_ctrl_bench;
    localparam int PACE = 40;
    localparam int CAL  = 30;
    localparam int LAT  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        gate_sel = 1'b0, gate_n = 1'b0;
    logic        adc_start, adc_done;
    logic [11:0] adc_val = 12'h000;
    logic [3:0]  chan_sel, slot_sel;
    logic        single_ended, local_gain_x10, auto_acq, filter_narrow;
    logic        read_low_sel, range_bipolar;
    logic [1:0]  global_gain;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int n_starts = 0, last_start = 0, prev_start = 0;
    int adc_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    daq_adc_ctrl #(.PACE_CYC(PACE), .CAL_CYC(CAL), .SYNC_STAGES(2)) u_daq_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gate_sel(gate_sel), .gate_n(gate_n), .adc_start(adc_start),
        .adc_done(adc_done), .adc_result(adc_val), .chan_sel(chan_sel),
        .single_ended(single_ended), .local_gain_x10(local_gain_x10),
        .auto_acq(auto_acq), .filter_narrow(filter_narrow), .slot_sel(slot_sel),
        .read_low_sel(read_low_sel), .range_bipolar(range_bipolar),
        .global_gain(global_gain)
    );

    // converter core model: done LAT cycles after a start is seen
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) adc_cnt <= 0;
        else if (adc_start) adc_cnt <= LAT;
        else if (adc_cnt != 0) adc_cnt <= adc_cnt - 1;
        if (rst_n && adc_start) begin
            prev_start <= last_start;
            last_start <= cyc;
            n_starts   <= n_starts + 1;
        end
    end
    assign adc_done = (adc_cnt == 1);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check({chan_sel, single_ended, local_gain_x10, auto_acq, filter_narrow} == 8'h00,
              "R10 cfg A after reset", int'(chan_sel), 0);
        check({slot_sel, read_low_sel, range_bipolar, global_gain} == 8'h00,
              "R10 cfg B after reset", int'(slot_sel), 0);
        check(adc_start == 1'b0, "R10 adc_start after reset", int'(adc_start), 0);
        bus_read(8'h80, d);
        check(d == 8'h00, "R10 status after reset", int'(d), 0);
        bus_read(8'h81, d);
        check(d == 8'h00, "R10 data after reset", int'(d), 0);
    endtask

    task automatic t_cfg_ports();
        logic [7:0] d;
        bus_write(8'h80, 8'hA5);
        check(chan_sel == 4'h5 && !single_ended && local_gain_x10 && !auto_acq && filter_narrow,
              "R1 port A 0xA5", int'({filter_narrow, auto_acq, local_gain_x10, single_ended, chan_sel}), 8'hA5);
        bus_write(8'h80, 8'h1C);
        check(chan_sel == 4'hC && single_ended && !local_gain_x10 && !filter_narrow,
              "R1 port A 0x1C", int'({filter_narrow, auto_acq, local_gain_x10, single_ended, chan_sel}), 8'h1C);
        bus_write(8'h81, 8'hB7);
        check(slot_sel == 4'h7 && read_low_sel && range_bipolar && global_gain == 2'd2,
              "R2 port B 0xB7", int'({global_gain, range_bipolar, read_low_sel, slot_sel}), 8'hB7);
        bus_write(8'h81, 8'h49);
        check(slot_sel == 4'h9 && !read_low_sel && !range_bipolar && global_gain == 2'd1,
              "R2 port B 0x49", int'({global_gain, range_bipolar, read_low_sel, slot_sel}), 8'h49);
        bus_read(8'h55, d);
        check(d == 8'h00, "R3 unmapped read", int'(d), 0);
    endtask

    task automatic t_regular();
        logic [7:0] d;
        int n0;
        adc_val = 12'hABC;
        n0 = n_starts;
        bus_write(8'h9B, 8'h00);
        check(adc_start == 1'b1, "R4 start pulse", int'(adc_start), 1);
        bus_read(8'h80, d);
        check(d == 8'h02, "R3 status converting", int'(d), 2);
        bus_write(8'h9B, 8'h00); // ignored: busy
        idle(10);
        check(n_starts - n0 == 1, "R4 start while busy ignored", n_starts - n0, 1);
        bus_read(8'h9B, d);
        check(d == 8'h01, "R6 eoc set", int'(d), 1);
        bus_read(8'h80, d);
        check(d == 8'h01, "R3 status eoc", int'(d), 1);
        bus_write(8'h81, 8'h10);
        bus_read(8'h80, d);
        check(d == 8'hC0, "R3 low byte", int'(d), 8'hC0);
        bus_read(8'h81, d);
        check(d == 8'hAB, "R3 high byte", int'(d), 8'hAB);
        bus_read(8'h9B, d);
        check(d == 8'h00, "R6 eoc cleared by high read", int'(d), 0);
        bus_write(8'h81, 8'h00);
    endtask

    task automatic t_hold_and_start_clear();
        logic [7:0] d;
        adc_val = 12'h123;
        bus_write(8'h9B, 8'h00);
        idle(10);
        bus_read(8'h9B, d);
        check(d == 8'h01, "R6 eoc before restart", int'(d), 1);
        adc_val = 12'h456;
        bus_write(8'h9B, 8'h00);
        bus_read(8'h9B, d);
        check(d == 8'h00, "R6 eoc cleared by start", int'(d), 0);
        bus_read(8'h81, d);
        check(d == 8'h12, "R5 data held during conversion", int'(d), 8'h12);
        idle(10);
        bus_read(8'h81, d);
        check(d == 8'h45, "R5 data updated on done", int'(d), 8'h45);
    endtask

    task automatic t_auto();
        logic [7:0] d;
        int n0, n1;
        adc_val = 12'h5A5;
        n0 = n_starts;
        bus_write(8'h80, 8'h40);
        idle(PACE * 4 + 5);
        check(n_starts - n0 >= 4, "R7 auto repeats", n_starts - n0, 4);
        check(last_start - prev_start == PACE, "R7 start spacing", last_start - prev_start, PACE);
        bus_read(8'h81, d);
        check(d == 8'h5A, "R7 auto data readable", int'(d), 8'h5A);
        bus_write(8'h80, 8'h00);
        idle(PACE + 10);
        n1 = n_starts;
        idle(PACE * 3);
        check(n_starts == n1, "R7 auto stops", n_starts - n1, 0);
    endtask

    task automatic t_gate();
        logic [7:0] d;
        int n0, k;
        gate_sel = 1'b1;
        gate_n = 1'b1;
        idle(4);
        n0 = n_starts;
        bus_write(8'h80, 8'h40);
        idle(PACE * 3);
        check(n_starts == n0, "R8 gate high suspends", n_starts - n0, 0);
        gate_n = 1'b0;
        idle(10);
        check(n_starts - n0 >= 1, "R8 gate low resumes", n_starts - n0, 1);
        idle(PACE);
        adc_val = 12'h9C3;
        k = n_starts;
        while (n_starts == k) @(negedge clk);
        gate_n = 1'b1;
        idle(PACE * 3);
        check(n_starts == k + 1, "R8 no start after suspend", n_starts - k, 1);
        bus_read(8'h81, d);
        check(d == 8'h9C, "R8 running conversion latched", int'(d), 8'h9C);
        bus_write(8'h80, 8'h00);
        gate_sel = 1'b0;
        gate_n = 1'b0;
        idle(PACE + 10);
    endtask

    task automatic t_recal();
        logic [7:0] d;
        int n0;
        bus_write(8'h80, 8'h35);
        bus_write(8'h81, 8'h20);
        adc_val = 12'h777;
        bus_write(8'h9B, 8'h00);
        bus_write(8'h9A, 8'h00);
        check({chan_sel, single_ended, local_gain_x10, auto_acq, filter_narrow,
               slot_sel, read_low_sel, range_bipolar, global_gain} == 16'h0000,
              "R9 cfg cleared", int'({chan_sel, slot_sel}), 0);
        bus_read(8'h80, d);
        check(d == 8'h04, "R9 status calibrating", int'(d), 4);
        n0 = n_starts;
        bus_write(8'h9B, 8'h00);
        idle(10);
        check(n_starts == n0, "R9 start blocked in cal", n_starts - n0, 0);
        bus_read(8'h81, d);
        check(d == 8'h9C, "R9 aborted result dropped", int'(d), 8'h9C);
        idle(CAL);
        bus_read(8'h80, d);
        check(d == 8'h00, "R9 cal finished", int'(d), 0);
        bus_write(8'h9B, 8'h00);
        check(adc_start == 1'b1, "R9 start accepted after cal", int'(adc_start), 1);
        idle(10);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_ports();
        t_regular();
        t_hold_and_start_clear();
        t_auto();
        t_gate();
        t_recal();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end
endmodule